// File: doc/BRIEF.md
# Shadow Taint-Tracking Datapath

This block is a small register datapath with a shadow copy that follows every value through the logic. It has four data registers, an adder/subtractor, and an unsigned less-than unit that takes the adder's result. Each data register has a taint register beside it. Each functional unit has a propagation stage that turns the operand tags into a result tag. An external controller drives the register write enables, the two operand selects and the add/subtract choice. The shadow path uses the same strobes in the same cycle, so a tag never falls out of step with its value.

Registers 0 and 1 take the two input parameters, and each parameter has its own tag port. Registers 2 and 3 take the adder/subtractor result. The return value is the combinational adder/subtractor output, and it comes with a tag port. The comparison flag also comes with a tag. A parameter sets the tag granularity. At the coarsest setting there is one tag bit per value. The finer settings give one tag bit per byte or one per bit. Arithmetic tags run upward toward more significant positions, because carries and borrows do.

Top module: `taint_shadow_dp`

## Requirements
- R1: When write enable k is high at a clock edge, data register k and taint register k are written in that same cycle. Register 0 takes `paramA`/`paramATag`, register 1 takes `paramB`/`paramBTag`, and registers 2 and 3 take `retVal`/`retTag`.
- R2: The tag width follows `GRAN`: code 0 gives 1 bit per value, code 1 gives DATA_W/8 bits (bit i covers data byte i), and code 2 gives DATA_W bits (bit i covers data bit i).
- R3: While `rstN` is low, every data register is zero, taint registers 0 and 1 are all ones, and taint registers 2 and 3 are all zeros.
- R4: Operand A is register `opASel` and operand B is register `opBSel`. Their tags are taken from the same-numbered taint registers using those same selects.
- R5: At code 0, `retTag` is the OR of the two operand tags.
- R6: At code 1, bit i of `retTag` is the OR of all operand byte-tag bits at positions 0..i.
- R7: At code 2, bit i of `retTag` is the OR of all operand bit-tag bits at positions 0..i.
- R8: `retVal` is opA+opB when `subtract` is 0 and opA-opB when it is 1, both modulo 2^DATA_W. The tag rule is the same for both.
- R9: `cmpLt` is 1 when `retVal` < opB (unsigned). `cmpLtTag` is the OR of every bit of both operand tags.
- R10: A register whose write enable is low keeps its value and its tag, whatever the parameter inputs and the result do.
- R11: When both operand tags are all zeros, `retTag` and `cmpLtTag` are zero for any operand values and any select values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| paramA | input | DATA_W | First input parameter |
| paramATag | input | TAG_W | Tag of the first parameter |
| paramB | input | DATA_W | Second input parameter |
| paramBTag | input | TAG_W | Tag of the second parameter |
| regWrEn | input | 4 | Write enable for each register |
| opASel | input | 2 | Register index for operand A |
| opBSel | input | 2 | Register index for operand B |
| subtract | input | 1 | 1 selects subtraction, 0 selects addition |
| retVal | output | DATA_W | Adder/subtractor result |
| retTag | output | TAG_W | Tag of the result |
| cmpLt | output | 1 | Result is less than operand B |
| cmpLtTag | output | 1 | Tag of the comparison flag |

## Verification
The embedded properties rely on the controller holding reset low long enough to clear the registers. They also rely on the controller giving the selects and strobes defined values from the first clock after reset. The load and hold checks compare each register only with the cycle before it, so they hold for any write-enable pattern, including several registers written at once.

The stimulus is written only on falling edges and never during reset. It mixes sparse and dense random tags with directed cases. Those cases include carry wrap-around, borrow from zero, all-clean operands, and registers read back after their enables were held low.

// File: rtl/taint_pkg.sv
package taint_pkg;

  typedef enum logic [1:0] {
    GRAN_VAR  = 2'd0,
    GRAN_BYTE = 2'd1,
    GRAN_BIT  = 2'd2
  } gran_e;

  localparam int REG_CNT    = 4;
  localparam int SEL_W      = $clog2(REG_CNT);
  localparam int PARAM_REGS = 2;

  typedef struct packed {
    logic [REG_CNT-1:0] wrEn;
    logic [SEL_W-1:0]   selA;
    logic [SEL_W-1:0]   selB;
    logic               doSub;
  } strobe_t;

  function automatic int tagWidth(gran_e g, int w);
    case (g)
      GRAN_VAR:  return 1;
      GRAN_BYTE: return w / 8;
      default:   return w;
    endcase
  endfunction

endpackage

// File: rtl/taint_ctrl.sv
module taint_ctrl
  import taint_pkg::*;
(
  input  logic [REG_CNT-1:0] regWrEn,
  input  logic [SEL_W-1:0]   opASel,
  input  logic [SEL_W-1:0]   opBSel,
  input  logic               subtract,
  output strobe_t            stb
);

  // One strobe bundle feeds the data path and the shadow path alike.
  always_comb begin
    stb.wrEn  = regWrEn;
    stb.selA  = opASel;
    stb.selB  = opBSel;
    stb.doSub = subtract;
  end

endmodule

// File: rtl/taint_prop.sv
module taint_prop
  import taint_pkg::*;
#(
  parameter gran_e GRAN  = GRAN_BYTE,
  parameter int    TAG_W = 2
) (
  input  logic [TAG_W-1:0] aTag,
  input  logic [TAG_W-1:0] bTag,
  output logic [TAG_W-1:0] resTag
);

  generate
    if (GRAN == GRAN_VAR) begin : g_var
      assign resTag = aTag | bTag;
    end else begin : g_ripple
      // Carries move upward, so taint at a position reaches every higher position.
      logic [TAG_W-1:0] merged;
      assign merged = aTag | bTag;
      always_comb begin
        logic run;
        run = 1'b0;
        for (int i = 0; i < TAG_W; i++) begin
          run       = run | merged[i];
          resTag[i] = run;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/taint_dp.sv
module taint_dp
  import taint_pkg::*;
#(
  parameter int    DATA_W = 16,
  parameter gran_e GRAN   = GRAN_BYTE,
  parameter int    TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] paramA,
  input  logic [TAG_W-1:0]  paramATag,
  input  logic [DATA_W-1:0] paramB,
  input  logic [TAG_W-1:0]  paramBTag,
  output logic [DATA_W-1:0] retVal,
  output logic [TAG_W-1:0]  retTag,
  output logic              cmpLt,
  output logic              cmpLtTag
);

  logic [DATA_W-1:0] dataQ [REG_CNT];
  logic [TAG_W-1:0]  tagQ  [REG_CNT];
  logic [DATA_W-1:0] dIn   [REG_CNT];
  logic [TAG_W-1:0]  tIn   [REG_CNT];

  logic [DATA_W-1:0] opA, opB, aluVal;
  logic [TAG_W-1:0]  opATag, opBTag, aluTag;

  // Operand mux tree and its shadow copy share the same selects.
  assign opA    = dataQ[stb.selA];
  assign opB    = dataQ[stb.selB];
  assign opATag = tagQ[stb.selA];
  assign opBTag = tagQ[stb.selB];

  assign aluVal = stb.doSub ? (opA - opB) : (opA + opB);

  taint_prop #(.GRAN(GRAN), .TAG_W(TAG_W)) u_addProp (
    .aTag  (opATag),
    .bTag  (opBTag),
    .resTag(aluTag)
  );

  // Compare unit chained after the adder; its propagation is chained the same way.
  assign cmpLt    = aluVal < opB;
  assign cmpLtTag = (|aluTag) | (|opBTag);

  assign retVal = aluVal;
  assign retTag = aluTag;

  generate
    for (genvar k = 0; k < REG_CNT; k++) begin : g_reg
      if (k == 0) begin : g_srcA
        assign dIn[k] = paramA;
        assign tIn[k] = paramATag;
      end else if (k == 1) begin : g_srcB
        assign dIn[k] = paramB;
        assign tIn[k] = paramBTag;
      end else begin : g_srcAlu
        assign dIn[k] = aluVal;
        assign tIn[k] = aluTag;
      end

      localparam logic [TAG_W-1:0] TAG_RST = (k < PARAM_REGS) ? '1 : '0;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dataQ[k] <= '0;
          tagQ[k]  <= TAG_RST;
        end else if (stb.wrEn[k]) begin
          dataQ[k] <= dIn[k];
          tagQ[k]  <= tIn[k];
        end
      end

      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !stb.wrEn[k] |=> ($stable(dataQ[k]) && $stable(tagQ[k])));
    end

    for (genvar i = 1; i < TAG_W; i++) begin : g_mono
      // R7
      prefix_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
        aluTag[i-1] |-> aluTag[i]);
    end
  endgenerate

  // R1
  param_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn[0] |=> (dataQ[0] == $past(paramA) && tagQ[0] == $past(paramATag)));

  // R11
  clean_ops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opATag == '0 && opBTag == '0) |-> (aluTag == '0 && !cmpLtTag));

  // R6
  taint_reach_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(opATag | opBTag)) |-> aluTag[TAG_W-1]);

  // R9
  flag_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|aluTag) |-> cmpLtTag);

endmodule

// File: rtl/taint_shadow_dp.sv
module taint_shadow_dp
  import taint_pkg::*;
#(
  parameter  int    DATA_W = 16,
  parameter  gran_e GRAN   = GRAN_BYTE,
  localparam int    TAG_W  = tagWidth(GRAN, DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] paramA,
  input  logic [TAG_W-1:0]  paramATag,
  input  logic [DATA_W-1:0] paramB,
  input  logic [TAG_W-1:0]  paramBTag,
  input  logic [REG_CNT-1:0] regWrEn,
  input  logic [SEL_W-1:0]  opASel,
  input  logic [SEL_W-1:0]  opBSel,
  input  logic              subtract,
  output logic [DATA_W-1:0] retVal,
  output logic [TAG_W-1:0]  retTag,
  output logic              cmpLt,
  output logic              cmpLtTag
);

  strobe_t stb;

  taint_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .opASel  (opASel),
    .opBSel  (opBSel),
    .subtract(subtract),
    .stb     (stb)
  );

  taint_dp #(.DATA_W(DATA_W), .GRAN(GRAN), .TAG_W(TAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .paramA   (paramA),
    .paramATag(paramATag),
    .paramB   (paramB),
    .paramBTag(paramBTag),
    .retVal   (retVal),
    .retTag   (retTag),
    .cmpLt    (cmpLt),
    .cmpLtTag (cmpLtTag)
  );

endmodule

// File: tb/taint_shadow_dp_bench.sv
module taint_shadow_dp_bench;
  import taint_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] paramA = '0, paramB = '0;
  logic [3:0]  regWrEn = '0;
  logic [1:0]  opASel = '0, opBSel = '0;
  logic        subtract = 1'b0;
  logic [15:0] aTagBit = '0, bTagBit = '0;
  logic [1:0]  aTagByte = '0, bTagByte = '0;
  logic        aTagVar = 1'b0, bTagVar = 1'b0;

  logic [15:0] valByte, valBit, valVar;
  logic [1:0]  tagByte;
  logic [15:0] tagBit;
  logic        tagVar;
  logic        ltByte, ltBit, ltVar, ltTagByte, ltTagBit, ltTagVar;

  taint_shadow_dp #(.DATA_W(16), .GRAN(GRAN_BYTE)) u_taint_shadow_dp (
    .clk(clk), .rstN(rstN), .paramA(paramA), .paramATag(aTagByte),
    .paramB(paramB), .paramBTag(bTagByte), .regWrEn(regWrEn),
    .opASel(opASel), .opBSel(opBSel), .subtract(subtract),
    .retVal(valByte), .retTag(tagByte), .cmpLt(ltByte), .cmpLtTag(ltTagByte));

  taint_shadow_dp #(.DATA_W(16), .GRAN(GRAN_BIT)) u_taint_shadow_dp_bit (
    .clk(clk), .rstN(rstN), .paramA(paramA), .paramATag(aTagBit),
    .paramB(paramB), .paramBTag(bTagBit), .regWrEn(regWrEn),
    .opASel(opASel), .opBSel(opBSel), .subtract(subtract),
    .retVal(valBit), .retTag(tagBit), .cmpLt(ltBit), .cmpLtTag(ltTagBit));

  taint_shadow_dp #(.DATA_W(16), .GRAN(GRAN_VAR)) u_taint_shadow_dp_var (
    .clk(clk), .rstN(rstN), .paramA(paramA), .paramATag(aTagVar),
    .paramB(paramB), .paramBTag(bTagVar), .regWrEn(regWrEn),
    .opASel(opASel), .opBSel(opBSel), .subtract(subtract),
    .retVal(valVar), .retTag(tagVar), .cmpLt(ltVar), .cmpLtTag(ltTagVar));

  // Reference model state
  logic [15:0] mData  [4];
  logic [15:0] mTBit  [4];
  logic [1:0]  mTByte [4];
  logic        mTVar  [4];

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  function automatic logic [15:0] ripple16(logic [15:0] v);
    logic [15:0] r;
    logic run;
    run = 1'b0;
    for (int i = 0; i < 16; i++) begin
      run  = run | v[i];
      r[i] = run;
    end
    return r;
  endfunction

  function automatic logic [1:0] ripple2(logic [1:0] v);
    return {v[1] | v[0], v[0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 4; k++) begin
      mData[k]  = '0;
      mTBit[k]  = (k < 2) ? 16'hFFFF : 16'h0;
      mTByte[k] = (k < 2) ? 2'b11 : 2'b00;
      mTVar[k]  = (k < 2);
    end
  endtask

  task automatic step(string lbl, logic [3:0] we, logic [1:0] sa, logic [1:0] sb,
                      logic sub, logic [15:0] pa, logic [15:0] pb,
                      logic [15:0] atb, logic [15:0] btb);
    logic [15:0] a, b, eVal, eTBit;
    logic [1:0]  eTByte;
    logic        eTVar;
    @(negedge clk);
    regWrEn = we; opASel = sa; opBSel = sb; subtract = sub;
    paramA = pa; paramB = pb;
    aTagBit = atb; bTagBit = btb;
    aTagByte = {|atb[15:8], |atb[7:0]};
    bTagByte = {|btb[15:8], |btb[7:0]};
    aTagVar = |atb; bTagVar = |btb;
    a = mData[sa]; b = mData[sb];
    eVal   = sub ? (a - b) : (a + b);
    eTBit  = ripple16(mTBit[sa] | mTBit[sb]);
    eTByte = ripple2(mTByte[sa] | mTByte[sb]);
    eTVar  = mTVar[sa] | mTVar[sb];
    #1;
    chk({lbl, "/R8 value byte"}, 32'(valByte), 32'(eVal));
    chk({lbl, "/R8 value bit"},  32'(valBit),  32'(eVal));
    chk({lbl, "/R8 value var"},  32'(valVar),  32'(eVal));
    chk({lbl, "/R6 byte tag"},   32'(tagByte), 32'(eTByte));
    chk({lbl, "/R7 bit tag"},    32'(tagBit),  32'(eTBit));
    chk({lbl, "/R5 var tag"},    32'(tagVar),  32'(eTVar));
    chk({lbl, "/R9 flag"},       32'({ltByte, ltBit, ltVar}), {29'd0, {3{eVal < b}}});
    chk({lbl, "/R9 flag tag"},   32'({ltTagByte, ltTagBit, ltTagVar}),
        {29'd0, |(mTByte[sa] | mTByte[sb]), |(mTBit[sa] | mTBit[sb]), eTVar});
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      if (we[k]) begin
        if (k == 0) begin
          mData[k] = pa; mTBit[k] = atb; mTByte[k] = aTagByte; mTVar[k] = aTagVar;
        end else if (k == 1) begin
          mData[k] = pb; mTBit[k] = btb; mTByte[k] = bTagByte; mTVar[k] = bTagVar;
        end else begin
          mData[k] = eVal; mTBit[k] = eTBit; mTByte[k] = eTByte; mTVar[k] = eTVar;
        end
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    // R3: reset state, before the first write
    #1;
    chk("R3 reset value", 32'(valBit), 32'h0);
    chk("R3 param tags after reset", 32'(tagBit), 32'hFFFF);
    @(negedge clk);
    rstN = 1'b1;
    step("R3", 4'b0000, 2'd0, 2'd1, 1'b0, 16'h1234, 16'h5678, 16'h0, 16'h0);
    step("R3", 4'b0000, 2'd2, 2'd3, 1'b0, 16'h1234, 16'h5678, 16'h0, 16'h0);

    // R1: load both parameters, then a taint on bit 0 ripples to all bits
    step("R1", 4'b0011, 2'd2, 2'd2, 1'b0, 16'h00FF, 16'h0001, 16'h0001, 16'h0000);
    step("R1", 4'b0000, 2'd0, 2'd1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    // R2/R6/R7: taint only in the upper byte stays in the upper byte
    step("R2", 4'b0011, 2'd0, 2'd1, 1'b0, 16'h0100, 16'h0200, 16'h0100, 16'h0000);
    step("R2", 4'b0000, 2'd0, 2'd1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    // R4: clean reg0 with tainted reg1, select reg0 twice
    step("R4", 4'b0011, 2'd0, 2'd0, 1'b0, 16'h00AA, 16'h0055, 16'h0000, 16'h8000);
    step("R4", 4'b0000, 2'd0, 2'd0, 1'b0, 16'h0, 16'h0, 16'hFFFF, 16'hFFFF);
    step("R4", 4'b0000, 2'd1, 2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
    // R8: carry wrap and borrow from zero; write results to reg2/reg3
    step("R8", 4'b0011, 2'd0, 2'd1, 1'b0, 16'hFFFF, 16'h0001, 16'h0, 16'h0);
    step("R8", 4'b0100, 2'd0, 2'd1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    step("R8", 4'b1000, 2'd2, 2'd1, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
    step("R8", 4'b0000, 2'd3, 2'd2, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    // R10: enables low while params change, registers keep old contents
    step("R10", 4'b0000, 2'd0, 2'd1, 1'b0, 16'hDEAD, 16'hBEEF, 16'hFFFF, 16'hFFFF);
    step("R10", 4'b0000, 2'd0, 2'd1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    // R11: clean operands stay clean regardless of values
    for (int n = 0; n < 40; n++)
      step("R11", 4'b0011, 2'($urandom), 2'($urandom), 1'($urandom),
           16'($urandom), 16'($urandom), 16'h0, 16'h0);
    // Mixed random: R5, R6, R7, R8, R9
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ta, tb;
      ta = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : (($urandom % 3 == 0) ? 16'($urandom) : 16'h0);
      tb = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      step("R5", 4'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
           16'($urandom), 16'($urandom), ta, tb);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule